// File: doc/BRIEF.md
# Narrow External Bus Access Sequencer

This block carries out one CPU-side memory access (byte, word or longword, read or write) over an 8-bit external bus. A wide access is broken into consecutive byte transfers with the most significant byte first. Each transfer is stretched by a programmable wait count. Every transfer after the first is also stretched by an idle count. The block runs on a single fast clock. A clock-enable strobe, `bus_tick`, marks each bus-clock edge, and all bus timing is counted in those ticks.

A requester presents a request while `req_ready` is high. The block then drives the address, the write byte and the strobes for each transfer. It collects read bytes into `rd_data` and pulses `done` for one fast cycle when the access is complete. Requests presented while an access is running are ignored. The wait and idle settings are captured when a request is accepted, so changing them later does not affect an access already in progress.

Top module: `narrow_bus_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, and both `bus_rd` and `bus_wr` are 0.
- R2: Size encoding on `req_size` is 0 = byte, 1 = word, and 2 or 3 = longword. An access makes 1, 2 or 4 byte transfers for these sizes.
- R3: Tick edges are counted from the accepting clock edge, that edge excluded. The first transfer takes 3+W ticks, and each further transfer takes 2+W+I ticks, where W is `cfg_wait` and I is `cfg_idle`. For a write, `done` is high in the fast cycle that follows the tick edge ending the last transfer.
- R4: A read raises `done` exactly one fast cycle later than a write of the same size and settings would.
- R5: Transfer k (counting from 0) of a write drives `bus_addr` = `req_addr`+k. It puts byte (N-1-k) of `req_wdata` on `bus_wdata`, byte 0 being bits 7:0, so the most significant byte goes to the lowest address. `bus_addr` holds steady throughout a transfer.
- R6: A read samples `bus_rdata` at the tick edge that ends each transfer. When `done` is high, `rd_data` holds the bytes with the first byte most significant, zero-extended to 32 bits.
- R7: `bus_wr` is high only during the final bus cycle of each write transfer. `bus_rd` is never high during a write access, and the two strobes are never high together.
- R8: `req_ready` is low from the accepting edge until the access completes. A request presented in that window causes no transfer and does not alter the running access.
- R9: `cfg_wait` and `cfg_idle` are sampled at acceptance. Changing them mid-access changes neither the timing nor the data of that access.
- R10: `done` is a single-cycle pulse, after which `req_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_tick | input | 1 | Bus-clock enable, one fast cycle per bus cycle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| req_addr | input | AW | Start byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| cfg_wait | input | WW | Wait count W |
| cfg_idle | input | WW | Idle count I |
| done | output | 1 | Access complete pulse |
| rd_data | output | 32 | Assembled read data, valid with done |
| bus_addr | output | AW | External byte address |
| bus_wdata | output | 8 | External write byte |
| bus_rdata | input | 8 | External read byte |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |

## Verification
For every access, the bench computes the number of tick edges K from the size, the wait count and the idle count. It counts the ticks it itself generates, starting with the edge after acceptance, and it reads `done` at the falling edge after the K-th tick edge for writes and one fast cycle later for reads. It also checks that `done` stayed low at every earlier falling edge. Write bytes and addresses are logged on each rising edge of the write strobe. Read data is checked against a fixed address-to-byte function while `done` is high. Tick ratios from 1 to 8 fast cycles and every wait/idle pair are covered.

// File: rtl/narrow_bus_seq.sv
module narrow_bus_seq #(
  parameter int AW = 16,
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_tick,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [WW-1:0] cfg_wait,
  input  logic [WW-1:0] cfg_idle,
  output logic          done,
  output logic [31:0]   rd_data,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic          bus_rd,
  output logic          bus_wr
);
  localparam int CW = WW + 2;

  logic          run, fin, done_q, wr_q;
  logic [WW-1:0] m_q;
  logic [CW-1:0] o_q, cnt;
  logic [1:0]    beat, last_beat, lb_in;
  logic [AW-1:0] base;
  logic [31:0]   wbuf, acc, walign;
  logic          accept, active, xfer_end, final_end;

  assign req_ready = !run && !fin;
  assign accept    = req_valid && req_ready;
  assign active    = cnt <= CW'(m_q) + CW'(2);
  assign xfer_end  = run && bus_tick && (cnt == CW'(1));
  assign final_end = xfer_end && (beat == last_beat);

  assign bus_addr  = base + AW'(beat);
  assign bus_wdata = wbuf[31:24];
  assign bus_rd    = run && !wr_q && active;
  assign bus_wr    = run && wr_q && (cnt == CW'(1));
  assign done      = done_q;
  assign rd_data   = acc;

  always_comb begin
    case (req_size)
      2'd0:    begin lb_in = 2'd0; walign = {req_wdata[7:0], 24'd0}; end
      2'd1:    begin lb_in = 2'd1; walign = {req_wdata[15:0], 16'd0}; end
      default: begin lb_in = 2'd3; walign = req_wdata; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; fin <= 1'b0; done_q <= 1'b0; wr_q <= 1'b0;
      m_q <= '0; o_q <= '0; cnt <= '0; beat <= '0; last_beat <= '0;
      base <= '0; wbuf <= '0; acc <= '0;
    end else begin
      done_q <= (final_end && wr_q) || fin;
      fin    <= final_end && !wr_q;
      if (accept) begin
        run       <= 1'b1;
        wr_q      <= req_write;
        m_q       <= cfg_wait;
        o_q       <= CW'(cfg_wait) + CW'(cfg_idle);
        cnt       <= CW'(cfg_wait) + CW'(3);
        beat      <= '0;
        last_beat <= lb_in;
        base      <= req_addr;
        wbuf      <= walign;
        acc       <= '0;
      end else if (xfer_end) begin
        if (!wr_q) acc <= {acc[23:0], bus_rdata};
        wbuf <= {wbuf[23:0], 8'd0};
        if (final_end) run <= 1'b0;
        else begin
          beat <= beat + 2'd1;
          cnt  <= o_q + CW'(2);
        end
      end else if (run && bus_tick) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !xfer_end) |=> $stable(bus_addr)); // R5
  AST_READ_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (final_end && !wr_q) |=> (!done && !req_ready)); // R4
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !final_end) |=> !req_ready); // R8
  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt != '0)); // R3
endmodule

// File: tb/narrow_bus_seq_test.sv
module narrow_bus_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [15:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [2:0] cfg_wait = 0, cfg_idle = 0;
  logic req_ready, done, bus_rd, bus_wr;
  logic [31:0] rd_data;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  int cyc = 0, ratio = 1;
  int n_checks = 0, n_errors = 0;
  int nwr = 0;
  logic [15:0] la [8];
  logic [7:0] ld [8];
  logic wr_prev = 0, bad_strobe = 0, cur_write = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick = (cyc % ratio) == ratio - 1;
  assign bus_rdata = bus_addr[7:0] ^ 8'hA5;

  narrow_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .bus_tick(tick), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_wait(cfg_wait),
    .cfg_idle(cfg_idle), .done(done), .rd_data(rd_data), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr));

  always @(posedge clk) begin
    wr_prev <= bus_wr;
    if (bus_wr && !wr_prev && nwr < 8) begin
      la[nwr] <= bus_addr;
      ld[nwr] <= bus_wdata;
      nwr <= nwr + 1;
    end
    if ((bus_rd && bus_wr) || (bus_rd && cur_write)) bad_strobe <= 1;
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int beats(input logic [1:0] sz);
    return sz == 0 ? 1 : (sz == 1 ? 2 : 4);
  endfunction

  task automatic access(input logic wr, input logic [1:0] sz, input logic [15:0] addr,
                        input logic [31:0] wd, input int m, input int idl,
                        input int rt, input logic disturb);
    int n, kk, k;
    logic early;
    logic [31:0] exp;
    n = beats(sz);
    kk = (3 + m) + (n - 1) * (2 + m + idl);
    @(negedge clk);
    ratio = rt; nwr = 0; bad_strobe = 0; cur_write = wr;
    check(req_ready, "R10 ready before access", req_ready, 1);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    cfg_wait = 3'(m); cfg_idle = 3'(idl);
    @(negedge clk);
    req_valid = 0;
    k = 0; early = 0;
    while (1) begin
      if (done) early = 1;
      if (disturb && k == 1) begin
        check(!req_ready, "R8 ready low while busy", req_ready, 0);
        req_valid = 1; req_addr = addr ^ 16'h0F0F; req_wdata = ~wd;
        cfg_wait = 3'(7 - m); cfg_idle = 3'(7 - idl);
      end
      if (disturb && k == 2) req_valid = 0;
      if (tick) k++;
      @(negedge clk);
      if (k == kk) break;
    end
    req_valid = 0;
    check(!early, "R3 done not early", early, 0);
    if (wr) begin
      check(done, disturb ? "R9 write done at formula tick" : "R3 write done at formula tick", done, 1);
    end else begin
      check(!done, "R4 read done not at write time", done, 0);
      @(negedge clk);
      check(done, "R4 read done one cycle late", done, 1);
      exp = 0;
      for (int i = 0; i < n; i++) exp = {exp[23:0], 8'((addr + 16'(i)) ^ 16'h00A5)};
      check(rd_data == exp, "R6 read assembly", rd_data, exp);
    end
    @(negedge clk);
    check(!done && req_ready, "R10 done single pulse", done, 0);
    check(nwr == (wr ? n : 0), wr ? "R2 transfer count" : "R8 no write on read", nwr, wr ? n : 0);
    check(!bad_strobe, "R7 strobe rules", bad_strobe, 0);
    if (wr) begin
      for (int i = 0; i < n && i < nwr; i++) begin
        check(la[i] == addr + 16'(i), "R5 write address", la[i], addr + 16'(i));
        check(ld[i] == 8'(wd >> (8 * (n - 1 - i))), "R5 write byte order", ld[i], 8'(wd >> (8 * (n - 1 - i))));
      end
    end
  endtask

  task automatic t_reset;
    #1;
    check(req_ready == 1, "R1 ready at reset", req_ready, 1);
    check(done == 0, "R1 done at reset", done, 0);
    check(!bus_rd && !bus_wr, "R1 strobes at reset", {bus_rd, bus_wr}, 0);
  endtask

  task automatic t_sizes;
    access(1, 2'd0, 16'h0100, 32'h0000_00C3, 0, 0, 1, 0);
    access(1, 2'd1, 16'h01FF, 32'h0000_BEEF, 0, 0, 2, 0);
    access(1, 2'd2, 16'h2000, 32'h1234_5678, 2, 3, 3, 0);
    access(1, 2'd3, 16'hFFFE, 32'hA1B2_C3D4, 1, 0, 1, 0);
    access(0, 2'd0, 16'h0042, 32'h0, 0, 0, 1, 0);
    access(0, 2'd1, 16'h3333, 32'h0, 1, 1, 4, 0);
    access(0, 2'd2, 16'h7000, 32'h0, 7, 7, 2, 0);
  endtask

  task automatic t_disturb;
    access(1, 2'd2, 16'h0500, 32'hDEAD_BEEF, 2, 1, 1, 1);
    access(0, 2'd2, 16'h0600, 32'h0, 0, 5, 1, 1);
    access(1, 2'd1, 16'h0700, 32'h0000_5AA5, 3, 2, 8, 1);
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 8; i++) begin
        access(1, 2'd2, 16'(m * 64 + i * 4), 32'h0102_0304 * (m + 1), m, i, 1, 0);
        access(0, 2'd1, 16'(m * 32 + i), 32'h0, m, i, 3, 0);
      end
  endtask

  logic finished = 0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    t_reset;
    @(negedge clk) rst_n = 1;
    t_reset;
    t_sizes;
    t_disturb;
    t_sweep;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule